// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a command decoder placed in front of a small on-chip flash array. A processor-style bus writes command bytes over one or two write cycles. These bytes decide what a read returns: the byte stored at the bus address, or an 8-bit status word. The same bytes launch timed program and block-erase operations on a behavioural byte array.

A program operation can only clear bits. After it stores the result, it checks that result against the byte that was requested. A bad erase confirmation byte is reported as a command-sequence error. Both error flags stay set until a dedicated clear command is written. While an operation runs, a ready output is low and status bit 7 reads 0. Starting an operation switches reads to status. Reads return to array contents only when the read-array command is written.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ready` is 1, reads return array contents, every array byte is 0xFF and both error flags are 0.
- R2: A write of 0xFF while idle selects array reads: `rdData` returns the byte stored at `addr`, combinationally, until another mode-changing command is written.
- R3: A write of 0x70 while idle selects status reads: `rdData` returns the status word at every address. Bit 7 is ready, bit 5 is the erase error flag, bit 4 is the program error flag, and bits 6 and 3..0 are 0.
- R4: A write of 0x40 followed by a second write programs the byte at that write's address. The stored value becomes the old value AND the written data, so no bit ever goes from 0 to 1.
- R5: Starting a program or an erase switches reads to status. Status reads continue after the operation ends, until 0xFF is written.
- R6: `ready` and status bit 7 are 0 for exactly PROG_CYCLES clock cycles after the program data write, and for ERASE_CYCLES cycles after the erase confirm write. They are 1 otherwise.
- R7: If the programmed byte differs from the requested data, status bit 4 is set. It stays set through later operations.
- R8: A write of 0x20 followed by a write of 0xD0 erases a block. Every byte of the block that holds the address of the 0xD0 write becomes 0xFF. A block is 2^BLOCK_W bytes, selected by the address bits above BLOCK_W. Bytes in other blocks are untouched.
- R9: If the write after 0x20 is not 0xD0, nothing is erased. Status bits 4 and 5 are both set, reads switch to status, and no busy period starts.
- R10: A single write of 0x50 while idle clears status bits 4 and 5 and leaves the read mode unchanged.
- R11: While busy, writes have no effect, and reads return the status word.
- R12: Any other byte written while idle has no effect on the read mode or on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Bus write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Bus address for reads and writes |
| wrData | input | 8 | Bus write data: a command byte or the data to program |
| rdData | output | 8 | Read data: an array byte or the status word |
| ready | output | 1 | 1 when idle, 0 while a program or erase runs |

## Verification
The bench uses ADDR_W = 6 and BLOCK_W = 4: 64 bytes in four blocks of 16. It sets PROG_CYCLES = 5 and ERASE_CYCLES = 9. With this size, every address can be programmed twice with two arithmetic patterns, and the whole array can be read back after each pass. The second pattern produces both passing and failing verifications. Each block can be erased in turn. Because the durations are short, the bench checks the full busy window of every operation cycle by cycle, and it injects a write in the middle of a busy window.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] CMD_PROGRAM     = 8'h40;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;

  typedef enum logic [1:0] {
    ST_IDLE, ST_PROG_ARG, ST_ERASE_ARG, ST_BUSY
  } ctlState_t;

  typedef struct packed {
    logic latchOp;
    logic commitProg;
    logic commitErase;
    logic clearErr;
    logic flagBadSeq;
  } ctlStrobe_t;
endpackage

// File: rtl/fcc_ctrl.sv
`timescale 1ns/1ps
module fcc_ctrl
  import fcc_pkg::*;
#(
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       statusMode
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             isErase;
  logic             isConfirm;
  logic             cntDone;

  assign isConfirm = (wrData == CMD_CONFIRM);
  assign cntDone   = (cnt == '0);
  assign busy      = (state == ST_BUSY);

  always_comb begin
    stb             = '0;
    stb.latchOp     = wrEn && ((state == ST_PROG_ARG) || (state == ST_ERASE_ARG && isConfirm));
    stb.clearErr    = wrEn && (state == ST_IDLE) && (wrData == CMD_CLEAR_ERR);
    stb.flagBadSeq  = wrEn && (state == ST_ERASE_ARG) && !isConfirm;
    stb.commitProg  = busy && cntDone && !isErase;
    stb.commitErase = busy && cntDone && isErase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      statusMode <= 1'b0;
      cnt        <= '0;
      isErase    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (wrEn) begin
          case (wrData)
            CMD_READ_ARRAY:  statusMode <= 1'b0;
            CMD_READ_STATUS: statusMode <= 1'b1;
            CMD_PROGRAM:     state <= ST_PROG_ARG;
            CMD_ERASE:       state <= ST_ERASE_ARG;
            default: ;
          endcase
        end
        ST_PROG_ARG: if (wrEn) begin
          state      <= ST_BUSY;
          isErase    <= 1'b0;
          cnt        <= CNT_W'(PROG_CYCLES - 1);
          statusMode <= 1'b1;
        end
        ST_ERASE_ARG: if (wrEn) begin
          statusMode <= 1'b1;
          if (isConfirm) begin
            state   <= ST_BUSY;
            isErase <= 1'b1;
            cnt     <= CNT_W'(ERASE_CYCLES - 1);
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn)) else $error("busy began without a write"); // R6
  AST_STATUS_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> statusMode) else $error("operation began in array mode"); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.commitProg, stb.commitErase, stb.clearErr, stb.flagBadSeq})) else $error("strobes overlap"); // R11
  AST_BAD_SEQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.flagBadSeq |=> !busy) else $error("bad sequence started work"); // R9
endmodule

// File: rtl/fcc_datapath.sv
`timescale 1ns/1ps
module fcc_datapath
  import fcc_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BLOCK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              ready,
  input  logic              statusMode,
  output logic [7:0]        rdData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BLK_HI = ADDR_W - BLOCK_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic              progErr;
  logic              eraseErr;
  logic [7:0]        merged;
  logic [7:0]        statusByte;
  logic [BLK_HI-1:0] opBlock;

  assign merged     = mem[opAddr] & opData;
  assign opBlock    = opAddr[ADDR_W-1:BLOCK_W];
  assign statusByte = {ready, 1'b0, eraseErr, progErr, 4'b0000};
  assign rdData     = (statusMode || !ready) ? statusByte : mem[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= '0;
    end else if (stb.latchOp) begin
      opAddr <= addr;
      opData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (stb.commitErase && (ADDR_W'(i) >> BLOCK_W) == ADDR_W'(opBlock))
          mem[i] <= 8'hFF;
        else if (stb.commitProg && ADDR_W'(i) == opAddr)
          mem[i] <= merged;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progErr  <= 1'b0;
      eraseErr <= 1'b0;
    end else if (stb.clearErr) begin
      progErr  <= 1'b0;
      eraseErr <= 1'b0;
    end else if (stb.flagBadSeq) begin
      progErr  <= 1'b1;
      eraseErr <= 1'b1;
    end else if (stb.commitProg && merged != opData) begin
      progErr  <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (progErr && !stb.clearErr) |=> progErr) else $error("program error dropped"); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearErr |=> (!progErr && !eraseErr)) else $error("clear left a flag"); // R10
  AST_NO_BIT_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitProg |=> ((mem[opAddr] & ~$past(mem[opAddr])) == 8'h00)) else $error("program raised a bit"); // R4
  AST_BAD_SEQ_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    stb.flagBadSeq |=> (progErr && eraseErr)) else $error("bad sequence not flagged"); // R9
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int BLOCK_W      = 4,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              ready
);
  ctlStrobe_t stb;
  logic       busy;
  logic       statusMode;

  assign ready = !busy;

  fcc_ctrl #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .stb(stb), .busy(busy), .statusMode(statusMode)
  );

  fcc_datapath #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .ready(ready), .statusMode(statusMode), .rdData(rdData)
  );
endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int AW = 6;
  localparam int BW = 4;
  localparam int PC = 5;
  localparam int EC = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic ready;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [7:0] model [DEPTH];
  bit e4 = 1'b0;
  bit e5 = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BLOCK_W(BW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ready(ready)
  );

  function automatic logic [7:0] expStatus(input bit rdy);
    return {rdy, 1'b0, e5, e4, 4'b0000};
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic writeCyc(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busyWindow(input int cyc, input bit inject);
    logic [7:0] v;
    for (int k = 0; k < cyc; k++) begin
      check8("R6 ready low", {7'd0, ready}, 8'd0);
      if (k == 0) begin
        readAt(6'h00, v);
        check8("R11 busy read", v, expStatus(1'b0));
      end
      if (inject && k == 1) begin
        addr = '0; wrData = 8'hFF; wrEn = 1'b1;
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
    end
    wrEn = 1'b0;
    check8("R6 ready high", {7'd0, ready}, 8'd1);
  endtask

  task automatic doProg(input logic [AW-1:0] a, input logic [7:0] d);
    logic [7:0] v;
    writeCyc(~a, 8'h40);
    writeCyc(a, d);
    busyWindow(PC, 1'b0);
    if ((model[a] & d) != d) e4 = 1'b1;
    model[a] = model[a] & d;
    readAt(a ^ 6'h15, v);
    check8("R5 R7 status after program", v, expStatus(1'b1));
  endtask

  task automatic doErase(input logic [AW-1:0] a, input bit inject);
    logic [7:0] v;
    writeCyc(6'h00, 8'h20);
    writeCyc(a, 8'hD0);
    busyWindow(EC, inject);
    for (int i = 0; i < DEPTH; i++)
      if ((i >> BW) == (int'(a) >> BW)) model[i] = 8'hFF;
    readAt(a, v);
    check8("R8 R11 status after erase", v, expStatus(1'b1));
  endtask

  task automatic sweepArray(input string req);
    logic [7:0] v;
    writeCyc(6'h00, 8'hFF);
    for (int i = 0; i < DEPTH; i++) begin
      readAt(AW'(i), v);
      check8(req, v, model[i]);
    end
  endtask

  initial begin
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    check8("R1 ready after reset", {7'd0, ready}, 8'd1);
    for (int i = 0; i < DEPTH; i++) begin
      readAt(AW'(i), v);
      check8("R1 erased array", v, 8'hFF);
    end

    writeCyc(6'h00, 8'h70);
    for (int i = 0; i < DEPTH; i++) begin
      readAt(AW'(i), v);
      check8("R3 R1 status any address", v, 8'h80);
    end
    writeCyc(6'h03, 8'h33);
    readAt(6'h07, v);
    check8("R12 stays in status", v, 8'h80);
    writeCyc(6'h00, 8'hFF);
    writeCyc(6'h05, 8'h9A);
    readAt(6'h05, v);
    check8("R12 stays in array", v, 8'hFF);

    for (int i = 0; i < DEPTH; i++) doProg(AW'(i), 8'((i * 29 + 7) & 8'hFF));
    sweepArray("R2 R4 first pass");

    for (int i = 0; i < DEPTH; i++) doProg(AW'(i), 8'(i) ^ 8'hA5);
    sweepArray("R4 second pass AND");
    writeCyc(6'h00, 8'h70);
    readAt(6'h11, v);
    check8("R7 sticky program error", v, expStatus(1'b1));

    writeCyc(6'h00, 8'h50);
    e4 = 1'b0; e5 = 1'b0;
    readAt(6'h2A, v);
    check8("R10 clear keeps status mode", v, 8'h80);

    doErase(6'h1F, 1'b1);
    readAt(6'h01, v);
    check8("R11 injected write ignored", v, expStatus(1'b1));
    sweepArray("R8 block one erased");

    writeCyc(6'h00, 8'h20);
    writeCyc(6'h2F, 8'h33);
    e4 = 1'b1; e5 = 1'b1;
    check8("R9 no busy", {7'd0, ready}, 8'd1);
    readAt(6'h04, v);
    check8("R9 both flags", v, 8'hB0);
    sweepArray("R9 array untouched");

    writeCyc(6'h00, 8'h50);
    e4 = 1'b0; e5 = 1'b0;
    readAt(6'h09, v);
    check8("R10 array mode kept after clear", v, model[9]);

    doProg(6'h22, 8'h3C);
    readAt(6'h22, v);
    check8("R5 status until read array", v, expStatus(1'b1));
    sweepArray("R5 R4 single program");

    for (int b = 0; b < (DEPTH >> BW); b++) doErase(AW'((b << BW) + (1 << BW) - 1), 1'b0);
    sweepArray("R8 all blocks erased");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule